// File: doc/BRIEF.md
# Scalar Execute Unit with Configuration Register File

This block executes already-decoded scalar operations for a small accelerator control core. It holds two register files. One is a 32-entry general file used for arithmetic, addresses and temporaries. The other is a 16-entry configuration file whose contents are driven at all times onto a wide output bus, where other compute units read them. Each operation arrives as a 4-bit operation code, three register indices, a 21-bit immediate field and a valid strobe.

The block covers several kinds of work. It runs register-register and register-immediate arithmetic and logic. It loads and stores through a simple byte-addressed local-memory port, using a base register plus an offset. It can write an immediate into either register file, and it can move values between the two files in both directions. Every operation that does not touch memory finishes in one cycle. A load stalls the unit until memory answers.

The control is a three-state machine:
- `ST_IDLE` accepts an operation whenever `op_valid` is high.
- An accepted load moves the machine `ST_IDLE -> ST_WAIT_RD`.
- It stays in `ST_WAIT_RD` until `mem_rvalid` arrives, then goes `ST_WAIT_RD -> ST_WRITE_LD`.
- `ST_WRITE_LD` writes the loaded word into the general file and always returns `ST_WRITE_LD -> ST_IDLE`.
- All other operations leave the machine in `ST_IDLE`.

`busy` is high in every state except `ST_IDLE`.

Top module: `scx_exec`

## Requirements
- R1: After a synchronous active-high `rst`, every general and configuration register reads zero, `cfg_bus` is all zero and `busy` is low.
- R2: Codes 0 (add), 1 (subtract) and 4 (multiply) write the low 32 bits of gen[rs] op gen[rt] into gen[rd], wrapping modulo 2^32, at the clock edge that accepts them.
- R3: Code 2 (maximum) writes the larger of gen[rs] and gen[rt] compared as signed numbers. Code 3 (equality) writes 1 when the two are equal and 0 otherwise.
- R4: Code 5 (AND) writes gen[rs] & gen[rt]. Codes 6 (add), 8 (AND) and 9 (OR) combine gen[rs] with `op_imm[10:0]` sign-extended to 32 bits; `op_imm[20:11]` has no effect on them.
- R5: Code 7 shifts gen[rs] left logically by the low 5 bits of the sign-extended immediate.
- R6: Code 12 writes `op_imm[20:0]` zero-extended into gen[rd].
- R7: Code 13 writes `op_imm[20:0]` zero-extended into cfg[`op_rd[3:0]`]. Entry k of the configuration file always appears on `cfg_bus[32k+31:32k]`.
- R8: Code 14 copies gen[rs] into cfg[`op_rd[3:0]`]. Code 15 copies cfg[`op_rs[3:0]`] into gen[rd].
- R9: Code 11 (store) raises `mem_req` and `mem_we` in its acceptance cycle, with `mem_addr` = gen[rs] + sign-extended `op_imm[10:0]` and `mem_wdata` = gen[rt]. It completes in that cycle and does not raise `busy`.
- R10: Code 10 (load) raises `mem_req` with `mem_we` low and the same address rule. `busy` is high from the next cycle through the cycle after the one where `mem_rvalid` is high. `mem_rdata` lands in gen[rd] at the edge that ends that last busy cycle.
- R11: While `busy` is high, `op_valid` is ignored: `mem_req` stays low, and neither register file changes.
- R12: General register 0 is an ordinary register: it holds what is written to it, and reading it returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | Operation code (see requirements) |
| op_rs | input | 5 | First source index |
| op_rt | input | 5 | Second source index |
| op_rd | input | 5 | Destination index |
| op_imm | input | 21 | Immediate field |
| busy | output | 1 | Unit stalled on a load; operations ignored |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cfg_bus | output | 512 | All configuration registers, entry k at bits 32k+31:32k |

## Verification
A wrong value inside the general file stays hidden until that register is read. The bench therefore follows each result with a move into the configuration file, and that move makes the value visible on `cfg_bus` one edge later. A corrupted configuration entry shows on `cfg_bus` right after the edge that wrote it. The bench compares the whole bus after every clock. A fault in the state machine shows on `busy`, or as a request during a stall, within the cycle it occurs. A load that writes back late, early or to the wrong register turns into a mismatch at the move that follows it.

// File: rtl/scx_pkg.sv
package scx_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MAX   = 4'd2,
        OP_EQ    = 4'd3,
        OP_MUL   = 4'd4,
        OP_AND   = 4'd5,
        OP_ADDI  = 4'd6,
        OP_SLLI  = 4'd7,
        OP_ANDI  = 4'd8,
        OP_ORI   = 4'd9,
        OP_LD    = 4'd10,
        OP_ST    = 4'd11,
        OP_GLI   = 4'd12,
        OP_SLI   = 4'd13,
        OP_G2S   = 4'd14,
        OP_S2G   = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_RD  = 2'd1,
        ST_WRITE_LD = 2'd2
    } state_e;

endpackage

// File: rtl/scx_alu.sv
module scx_alu
    import scx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 11,
    parameter int LI_W  = 21
) (
    input  op_e              op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [XLEN-1:0]  cfg_val,
    input  logic [LI_W-1:0]  imm,
    output logic [XLEN-1:0]  res,
    output logic [XLEN-1:0]  addr
);
    localparam int SH_W = $clog2(XLEN);

    logic [XLEN-1:0] simm;
    logic [XLEN-1:0] zimm;
    logic [XLEN-1:0] prod;

    assign simm = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm[IMM_W-1:0]};
    assign zimm = {{(XLEN-LI_W){1'b0}}, imm};
    assign prod = a * b;
    assign addr = a + simm;

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_MAX:  res = ($signed(a) > $signed(b)) ? a : b;
            OP_EQ:   res = {{(XLEN-1){1'b0}}, (a == b)};
            OP_MUL:  res = prod;
            OP_AND:  res = a & b;
            OP_ADDI: res = a + simm;
            OP_SLLI: res = a << simm[SH_W-1:0];
            OP_ANDI: res = a & simm;
            OP_ORI:  res = a | simm;
            OP_GLI:  res = zimm;
            OP_SLI:  res = zimm;
            OP_G2S:  res = a;
            OP_S2G:  res = cfg_val;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/scx_grf.sv
module scx_grf #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra,
    input  logic [AW-1:0]   rb,
    output logic [XLEN-1:0] qa,
    output logic [XLEN-1:0] qb,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [XLEN-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];

    // R12
    r0_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (regs[0] == $past(wdata)));

endmodule

// File: rtl/scx_srf.sv
module scx_srf #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         ra,
    output logic [XLEN-1:0]       qa,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [XLEN-1:0]       wdata,
    output logic [DEPTH*XLEN-1:0] cfg_bus
);
    logic [XLEN-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign qa = regs[ra];

    for (genvar k = 0; k < DEPTH; k++) begin : g_export
        assign cfg_bus[k*XLEN +: XLEN] = regs[k];
    end

    // R7
    srf_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_bus[$past(waddr)*XLEN +: XLEN] == $past(wdata)));

endmodule

// File: rtl/scx_exec.sv
module scx_exec
    import scx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int GRF_DEPTH = 32,
    parameter int SRF_DEPTH = 16,
    parameter int IMM_W     = 11,
    parameter int LI_W      = 21,
    localparam int GRF_AW   = $clog2(GRF_DEPTH),
    localparam int SRF_AW   = $clog2(SRF_DEPTH),
    localparam int CFG_W    = SRF_DEPTH * XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [GRF_AW-1:0] op_rs,
    input  logic [GRF_AW-1:0] op_rt,
    input  logic [GRF_AW-1:0] op_rd,
    input  logic [LI_W-1:0]   op_imm,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [CFG_W-1:0]  cfg_bus
);
    op_e               opc;
    state_e            state, state_nx;
    logic              accept;
    logic              wr_gen, wr_cfg;
    logic [XLEN-1:0]   gen_a, gen_b, cfg_q, alu_res, alu_addr;
    logic              grf_we, srf_we;
    logic [GRF_AW-1:0] grf_waddr;
    logic [XLEN-1:0]   grf_wdata;
    logic [GRF_AW-1:0] ld_rd_q;
    logic [XLEN-1:0]   ld_data_q;

    assign opc    = op_e'(op_code);
    assign accept = op_valid && (state == ST_IDLE);

    always_comb begin
        case (opc)
            OP_ADD, OP_SUB, OP_MAX, OP_EQ, OP_MUL, OP_AND,
            OP_ADDI, OP_SLLI, OP_ANDI, OP_ORI, OP_GLI, OP_S2G: wr_gen = 1'b1;
            default: wr_gen = 1'b0;
        endcase
        wr_cfg = (opc == OP_SLI) || (opc == OP_G2S);
    end

    scx_grf #(.XLEN(XLEN), .DEPTH(GRF_DEPTH)) u_grf (
        .clk   (clk),
        .rst   (rst),
        .ra    (op_rs),
        .rb    (op_rt),
        .qa    (gen_a),
        .qb    (gen_b),
        .we    (grf_we),
        .waddr (grf_waddr),
        .wdata (grf_wdata)
    );

    scx_srf #(.XLEN(XLEN), .DEPTH(SRF_DEPTH)) u_srf (
        .clk     (clk),
        .rst     (rst),
        .ra      (op_rs[SRF_AW-1:0]),
        .qa      (cfg_q),
        .we      (srf_we),
        .waddr   (op_rd[SRF_AW-1:0]),
        .wdata   (alu_res),
        .cfg_bus (cfg_bus)
    );

    scx_alu #(.XLEN(XLEN), .IMM_W(IMM_W), .LI_W(LI_W)) u_alu (
        .op      (opc),
        .a       (gen_a),
        .b       (gen_b),
        .cfg_val (cfg_q),
        .imm     (op_imm),
        .res     (alu_res),
        .addr    (alu_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept && opc == OP_LD) state_nx = ST_WAIT_RD;
            ST_WAIT_RD:  if (mem_rvalid) state_nx = ST_WRITE_LD;
            ST_WRITE_LD: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // load bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_rd_q   <= '0;
            ld_data_q <= '0;
        end else begin
            if (accept && opc == OP_LD) ld_rd_q <= op_rd;
            if (state == ST_WAIT_RD && mem_rvalid) ld_data_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        grf_we    = 1'b0;
        srf_we    = 1'b0;
        grf_waddr = op_rd;
        grf_wdata = alu_res;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                mem_req = accept && (opc == OP_LD || opc == OP_ST);
                mem_we  = accept && (opc == OP_ST);
                grf_we  = accept && wr_gen;
                srf_we  = accept && wr_cfg;
            end
            ST_WAIT_RD: begin
            end
            ST_WRITE_LD: begin
                grf_we    = 1'b1;
                grf_waddr = ld_rd_q;
                grf_wdata = ld_data_q;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr  = alu_addr;
    assign mem_wdata = gen_b;

    // R10
    ld_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> busy);

    // R10
    ld_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE_LD) |=> !busy);

    // R9
    st_single_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> !busy);

    // R11
    stall_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_RD) |=> $stable(cfg_bus));

    // R3
    eq_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_EQ) |-> (alu_res[XLEN-1:1] == '0));

endmodule

// File: tb/test_scx_exec.sv
`timescale 1ns/1ps
module test_scx_exec;
    localparam logic [3:0] C_ADD = 0, C_SUB = 1, C_MAX = 2, C_EQ = 3, C_MUL = 4,
        C_AND = 5, C_ADDI = 6, C_SLLI = 7, C_ANDI = 8, C_ORI = 9, C_LD = 10,
        C_ST = 11, C_GLI = 12, C_SLI = 13, C_G2S = 14, C_S2G = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [4:0]   op_rs = '0, op_rt = '0, op_rd = '0;
    logic [20:0]  op_imm = '0;
    logic         busy, mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_rvalid = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic [511:0] cfg_bus;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] gm [32];
    logic [31:0] sm [16];
    logic        exp_busy;

    always #2 clk = ~clk;

    scx_exec i_scx_exec (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_rs(op_rs), .op_rt(op_rt), .op_rd(op_rd), .op_imm(op_imm),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cfg_bus(cfg_bus)
    );

    function automatic logic [31:0] sx(logic [20:0] i);
        return {{21{i[10]}}, i[10:0]};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int bad_k = -1;
        chk(busy == exp_busy, tag, 32'(busy), 32'(exp_busy));
        for (int k = 0; k < 16; k++)
            if (bad_k < 0 && cfg_bus[k*32 +: 32] !== sm[k]) bad_k = k;
        if (bad_k < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, cfg_bus[bad_k*32 +: 32], sm[bad_k]);
    endtask

    // reference model: effect of one accepted non-load operation
    task automatic model(logic [3:0] c, int rs, int rt, int rd, logic [20:0] imm);
        logic [31:0] a = gm[rs];
        logic [31:0] b = gm[rt];
        logic [31:0] s = sx(imm);
        logic [31:0] z = {11'd0, imm};
        case (c)
            C_ADD:  gm[rd] = a + b;
            C_SUB:  gm[rd] = a - b;
            C_MAX:  gm[rd] = ($signed(a) > $signed(b)) ? a : b;
            C_EQ:   gm[rd] = (a == b) ? 32'd1 : 32'd0;
            C_MUL:  gm[rd] = a * b;
            C_AND:  gm[rd] = a & b;
            C_ADDI: gm[rd] = a + s;
            C_SLLI: gm[rd] = a << s[4:0];
            C_ANDI: gm[rd] = a & s;
            C_ORI:  gm[rd] = a | s;
            C_GLI:  gm[rd] = z;
            C_SLI:  sm[rd % 16] = z;
            C_G2S:  sm[rd % 16] = a;
            C_S2G:  gm[rd] = sm[rs % 16];
            default: ;
        endcase
    endtask

    task automatic do_op(logic [3:0] c, int rs, int rt, int rd, logic [20:0] imm, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_rs = 5'(rs); op_rt = 5'(rt);
        op_rd = 5'(rd); op_imm = imm;
        #1;
        if (c == C_ST) begin
            chk(mem_req && mem_we, tag, {30'd0, mem_req, mem_we}, 32'd3);
            chk(mem_addr == gm[rs] + sx(imm), tag, mem_addr, gm[rs] + sx(imm));
            chk(mem_wdata == gm[rt], tag, mem_wdata, gm[rt]);
        end else begin
            chk(!mem_req, tag, 32'(mem_req), 32'd0);
        end
        model(c, rs, rt, rd, imm);
        @(posedge clk); #1;
        op_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic peek(int r, string tag);
        do_op(C_G2S, r, 0, 15, 21'd0, tag);
    endtask

    task automatic do_load(int rs, int rd, logic [20:0] imm, int lat,
                           logic [31:0] data, string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = C_LD; op_rs = 5'(rs); op_rd = 5'(rd); op_imm = imm;
        #1;
        chk(mem_req && !mem_we, tag, {30'd0, mem_req, mem_we}, 32'd2);
        chk(mem_addr == gm[rs] + sx(imm), tag, mem_addr, gm[rs] + sx(imm));
        @(posedge clk); #1;
        op_valid = 1'b0;
        exp_busy = 1'b1;
        compare_all(tag);
        for (int i = 0; i < lat; i++) begin
            // R11: operations offered during the stall must be dropped
            @(negedge clk);
            op_valid = 1'b1;
            op_code = (i % 2 == 0) ? C_GLI : C_SLI;
            op_rd = (i % 2 == 0) ? 5'd5 : 5'd6;
            op_imm = 21'd77;
            #1;
            chk(!mem_req, "R11", 32'(mem_req), 32'd0);
            @(posedge clk); #1;
            op_valid = 1'b0;
            compare_all("R11");
        end
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = data;
        @(posedge clk); #1;
        mem_rvalid = 1'b0; mem_rdata = 32'hBAD0BAD0;
        compare_all(tag);
        @(posedge clk); #1;
        gm[rd] = data;
        exp_busy = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) gm[i] = '0;
        for (int i = 0; i < 16; i++) sm[i] = '0;
        exp_busy = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        compare_all("R1");
        peek(7, "R1");
        peek(0, "R1");

        // R6 general immediate load, including the largest value
        do_op(C_GLI, 0, 0, 1, 21'h01000, "R6");
        do_op(C_GLI, 0, 0, 2, 21'h1FFFFF, "R6");
        peek(2, "R6");

        // R2 add, subtract with wrap, multiply truncation
        do_op(C_ADD, 1, 2, 3, 21'd0, "R2");  peek(3, "R2");
        do_op(C_SUB, 1, 2, 4, 21'd0, "R2");  peek(4, "R2");
        do_op(C_MUL, 2, 2, 5, 21'd0, "R2");  peek(5, "R2");

        // R4 sign-extended add immediate, R3 signed max and equality
        do_op(C_GLI, 0, 0, 6, 21'd5, "R6");
        do_op(C_ADDI, 6, 0, 7, 21'h0007F8, "R4");  peek(7, "R4");
        do_op(C_MAX, 7, 6, 8, 21'd0, "R3");  peek(8, "R3");
        do_op(C_MAX, 6, 7, 9, 21'd0, "R3");  peek(9, "R3");
        do_op(C_EQ, 6, 6, 10, 21'd0, "R3");  peek(10, "R3");
        do_op(C_EQ, 6, 7, 11, 21'd0, "R3");  peek(11, "R3");

        // R4 logic, upper immediate bits must not matter
        do_op(C_ANDI, 2, 0, 12, 21'h1550FF, "R4"); peek(12, "R4");
        do_op(C_ORI, 12, 0, 13, 21'h1FF880, "R4"); peek(13, "R4");
        do_op(C_ORI, 6, 0, 13, 21'h000400, "R4");  peek(13, "R4");
        do_op(C_AND, 2, 1, 14, 21'd0, "R4");       peek(14, "R4");

        // R5 shift uses low 5 bits of the sign-extended immediate
        do_op(C_SLLI, 6, 0, 15, 21'd33, "R5");    peek(15, "R5");
        do_op(C_SLLI, 6, 0, 16, 21'h0007FF, "R5"); peek(16, "R5");

        // R7 configuration immediates; index from op_rd[3:0]
        do_op(C_SLI, 0, 0, 3, 21'd8, "R7");
        do_op(C_SLI, 0, 0, 20, 21'h1FFFFF, "R7");
        // R8 moves between files
        do_op(C_G2S, 4, 0, 5, 21'd0, "R8");
        do_op(C_S2G, 3, 0, 17, 21'd0, "R8");  peek(17, "R8");
        do_op(C_S2G, 20, 0, 18, 21'd0, "R8"); peek(18, "R8");

        // R9 stores with positive and negative offsets
        do_op(C_ST, 1, 3, 0, 21'd64, "R9");
        do_op(C_ST, 1, 0, 0, 21'h0007F0, "R9");

        // R10 load with stall into register 0, R11 ignored ops, R12
        do_load(1, 0, 21'd4, 3, 32'hDEADBEEF, "R10");
        peek(0, "R12");
        peek(5, "R11");
        do_load(1, 19, 21'h0007FC, 0, 32'h12345678, "R10");
        peek(19, "R10");

        // R12 register 0 as an ordinary operand and destination
        do_op(C_GLI, 0, 0, 0, 21'd100, "R12");
        do_op(C_ADD, 0, 0, 20, 21'd0, "R12"); peek(20, "R12");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule